// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the clause-22 style management registers of a 10/100 Ethernet PHY and serves them over a parallel access port. Each access carries a 5-bit PHY address and a 5-bit register index. A write also carries 16 bits of data, and the selected register is always presented on a 16-bit read bus. Only accesses whose PHY address equals the `PHY_ADDR` parameter reach the registers. Any other address reads as all ones and cannot change anything.

The block stores the basic control word and the advertisement word. The basic status word and the link-partner ability word are built from a registered copy of the `linkOk` input, so link changes appear without any software access. Indices 2 and 3 return identifier constants set by parameters. Setting bit 15 in a control write restores the control and advertisement defaults, and the written value is not kept. Writes are taken on the rising clock edge. Reads are combinational from the current address, index and register state.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, index 0 (control) reads 0x3100: bit 13 is 100 Mb/s, bit 12 is autonegotiation enable and bit 8 is full duplex. Index 4 (advertisement) reads 0x01E1: bits 8..5 are 100TX FD, 100TX HD, 10 FD and 10 HD, and bits 4..0 hold selector 00001.
- R2: A read whose PHY address differs from `PHY_ADDR` returns 0xFFFF, whatever the register index.
- R3: A write whose PHY address differs from `PHY_ADDR` changes no register.
- R4: While the link is up, index 1 (status) reads 0x786C. This is the ability bits 14..11, bit 6 (preamble suppression) and bit 3 (autonegotiation ability), plus bit 5 (autonegotiation complete) and bit 2 (link up). Index 5 (partner) reads 0x01E1.
- R5: While the link is down, status reads 0x7848, with bits 5 and 2 clear. Partner reads 0x0080, which is 100TX half duplex only.
- R6: A change on `linkOk` shows in the status and partner words after exactly one rising clock edge, with no access needed.
- R7: A control write with bit 15 set restores the R1 values of control and advertisement and does not store the written value. Status and partner keep following the link state.
- R8: A control write with bit 15 clear stores the written value exactly.
- R9: A write to index 4 stores the written value in the advertisement register.
- R10: Writes to indices 1, 2, 3, 5 and 6 leave every readable value unchanged.
- R11: Index 2 reads parameter `ID_HI` and index 3 reads parameter `ID_LO`.
- R12: Index 6, indices 7 to 31 and every other undefined index read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mgmtWrEn | input | 1 | Write strobe, sampled on the rising edge |
| mgmtPhyAddr | input | 5 | PHY address of the access |
| mgmtRegIdx | input | 5 | Register index of the access |
| mgmtWrData | input | 16 | Write data |
| mgmtRdData | output | 16 | Read data for the current address and index |
| linkOk | input | 1 | Link state from the line side, 1 means up |

## Verification
The hardest case to reach is a soft reset issued while the link is down. The control and advertisement words must return to their defaults, but the status and partner words must keep showing a down link rather than any reset pattern. The stimulus first drops `linkOk`, then changes control and advertisement away from their defaults, then issues a control write with bit 15 set and other bits set. It then reads all four words. The link-edge timing is checked by reading status in the same cycle as the `linkOk` change and again one edge later.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  parameter int ADDR_W = 5;
  parameter int IDX_W  = 5;
  parameter int DATA_W = 16;

  parameter int CTL_RST_BIT = 15;

  parameter logic [DATA_W-1:0] CTL_DEFAULT    = 16'h3100;
  parameter logic [DATA_W-1:0] STAT_BASE      = 16'h7848;
  parameter logic [DATA_W-1:0] STAT_LINK_BITS = 16'h0024;
  parameter logic [DATA_W-1:0] ADV_DEFAULT    = 16'h01E1;
  parameter logic [DATA_W-1:0] LP_DOWN        = 16'h0080;
  parameter logic [DATA_W-1:0] LP_UP_EXTRA    = 16'h0161;
  parameter logic [DATA_W-1:0] ALL_ONES       = '1;

  parameter logic [IDX_W-1:0] IDX_CTL  = 5'd0;
  parameter logic [IDX_W-1:0] IDX_STAT = 5'd1;
  parameter logic [IDX_W-1:0] IDX_ID1  = 5'd2;
  parameter logic [IDX_W-1:0] IDX_ID2  = 5'd3;
  parameter logic [IDX_W-1:0] IDX_ADV  = 5'd4;
  parameter logic [IDX_W-1:0] IDX_LP   = 5'd5;

  typedef enum logic [2:0] {
    SEL_ONES, SEL_CTL, SEL_STAT, SEL_ID1, SEL_ID2, SEL_ADV, SEL_LP, SEL_ZERO
  } read_sel_e;

  typedef struct packed {
    logic wrReq;
    logic addrHit;
    logic wrCtl;
    logic ctlSoftRst;
    logic wrAdv;
  } strobe_t;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import mgmt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strobe,
  output read_sel_e         readSel
);
  logic addrHit;
  logic ctlWrite;

  assign addrHit  = (phyAddr == PHY_ADDR);
  assign ctlWrite = wrEn && addrHit && (regIdx == IDX_CTL);

  always_comb begin
    strobe.wrReq      = wrEn;
    strobe.addrHit    = addrHit;
    strobe.wrCtl      = ctlWrite && !wrData[CTL_RST_BIT];
    strobe.ctlSoftRst = ctlWrite && wrData[CTL_RST_BIT];
    strobe.wrAdv      = wrEn && addrHit && (regIdx == IDX_ADV);
  end

  always_comb begin
    if (!addrHit) begin
      readSel = SEL_ONES;
    end else begin
      unique case (regIdx)
        IDX_CTL:  readSel = SEL_CTL;
        IDX_STAT: readSel = SEL_STAT;
        IDX_ID1:  readSel = SEL_ID1;
        IDX_ID2:  readSel = SEL_ID2;
        IDX_ADV:  readSel = SEL_ADV;
        IDX_LP:   readSel = SEL_LP;
        default:  readSel = SEL_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/phy_mgmt_dpath.sv
module phy_mgmt_dpath
  import mgmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_HI = 16'h1A2B,
  parameter logic [DATA_W-1:0] ID_LO = 16'hC0D5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  read_sel_e         readSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              linkOk,
  output logic [DATA_W-1:0] rdData
);
  logic              linkQ;
  logic [DATA_W-1:0] ctlReg;
  logic [DATA_W-1:0] advReg;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] partnerWord;

  // Link copy tracks the pin regardless of reset so it is valid at release.
  always_ff @(posedge clk) linkQ <= linkOk;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.ctlSoftRst) begin
      ctlReg <= CTL_DEFAULT;
      advReg <= ADV_DEFAULT;
    end else begin
      if (strobe.wrCtl) ctlReg <= wrData;
      if (strobe.wrAdv) advReg <= wrData;
    end
  end

  assign statusWord  = linkQ ? (STAT_BASE | STAT_LINK_BITS) : STAT_BASE;
  assign partnerWord = linkQ ? (LP_DOWN | LP_UP_EXTRA) : LP_DOWN;

  always_comb begin
    unique case (readSel)
      SEL_ONES: rdData = ALL_ONES;
      SEL_CTL:  rdData = ctlReg;
      SEL_STAT: rdData = statusWord;
      SEL_ID1:  rdData = ID_HI;
      SEL_ID2:  rdData = ID_LO;
      SEL_ADV:  rdData = advReg;
      SEL_LP:   rdData = partnerWord;
      default:  rdData = '0;
    endcase
  end

  // R7: soft reset restores defaults and drops the written word
  p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctlSoftRst |=> (ctlReg == CTL_DEFAULT) && (advReg == ADV_DEFAULT));

  // R8: plain control write lands as written
  p_ctl_store_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCtl |=> ctlReg == $past(wrData));

  // R9: advertisement write lands as written
  p_adv_store_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrAdv && !strobe.ctlSoftRst) |=> advReg == $past(wrData));

  // R3: foreign-address write leaves stored words alone
  p_foreign_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrReq && !strobe.addrHit) |=> $stable(ctlReg) && $stable(advReg));

  // R6: link bits of status follow the pin one edge later
  p_link_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusWord[2] == $past(linkOk)) && (statusWord[5] == $past(linkOk)));

  // R5: partner word with link down shows 100TX half duplex alone
  p_partner_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(linkOk) |-> $onehot0(partnerWord) && partnerWord[7]);
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import mgmt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1,
  parameter logic [DATA_W-1:0] ID_HI    = 16'h1A2B,
  parameter logic [DATA_W-1:0] ID_LO    = 16'hC0D5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mgmtWrEn,
  input  logic [ADDR_W-1:0] mgmtPhyAddr,
  input  logic [IDX_W-1:0]  mgmtRegIdx,
  input  logic [DATA_W-1:0] mgmtWrData,
  output logic [DATA_W-1:0] mgmtRdData,
  input  logic              linkOk
);
  strobe_t   strobe;
  read_sel_e readSel;

  phy_mgmt_ctrl #(.PHY_ADDR(PHY_ADDR)) u_ctrl (
    .wrEn   (mgmtWrEn),
    .phyAddr(mgmtPhyAddr),
    .regIdx (mgmtRegIdx),
    .wrData (mgmtWrData),
    .strobe (strobe),
    .readSel(readSel)
  );

  phy_mgmt_dpath #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .readSel(readSel),
    .wrData (mgmtWrData),
    .linkOk (linkOk),
    .rdData (mgmtRdData)
  );
endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;
  localparam logic [4:0]  OWN   = 5'd1;
  localparam logic [15:0] IDH   = 16'h1A2B;
  localparam logic [15:0] IDL   = 16'hC0D5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  phyAddr = OWN;
  logic [4:0]  regIdx = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        linkOk = 1'b1;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  phy_mgmt_regs #(.PHY_ADDR(OWN), .ID_HI(IDH), .ID_LO(IDL)) uut (
    .clk(clk), .rstN(rstN), .mgmtWrEn(wrEn), .mgmtPhyAddr(phyAddr),
    .mgmtRegIdx(regIdx), .mgmtWrData(wrData), .mgmtRdData(rdData),
    .linkOk(linkOk)
  );

  task automatic doWrite(input logic [4:0] a, input logic [4:0] i, input logic [15:0] d);
    @(negedge clk);
    phyAddr = a; regIdx = i; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [4:0] a, input logic [4:0] i,
                            input logic [15:0] exp, input string tag);
    phyAddr = a; regIdx = i;
    #0.5;
    compared++;
    if (rdData !== exp) begin
      mismatched++;
      $display("FAIL %s idx=%0d actual=%h expected=%h", tag, i, rdData, exp);
    end
  endtask

  task automatic testResetState();
    expectRead(OWN, 5'd0, 16'h3100, "R1 ctl");
    expectRead(OWN, 5'd4, 16'h01E1, "R1 adv");
    expectRead(OWN, 5'd1, 16'h786C, "R4 status up");
    expectRead(OWN, 5'd5, 16'h01E1, "R4 partner up");
    expectRead(OWN, 5'd2, IDH, "R11 id hi");
    expectRead(OWN, 5'd3, IDL, "R11 id lo");
  endtask

  task automatic testLinkEdge();
    @(negedge clk);
    linkOk = 1'b0;
    expectRead(OWN, 5'd1, 16'h786C, "R6 before edge");
    @(negedge clk);
    expectRead(OWN, 5'd1, 16'h7848, "R5 status down");
    expectRead(OWN, 5'd5, 16'h0080, "R5 partner down");
    @(negedge clk);
    linkOk = 1'b1;
    @(negedge clk);
    expectRead(OWN, 5'd1, 16'h786C, "R6 status back up");
    expectRead(OWN, 5'd5, 16'h01E1, "R6 partner back up");
  endtask

  task automatic testPlainWrites();
    doWrite(OWN, 5'd0, 16'h1200);
    expectRead(OWN, 5'd0, 16'h1200, "R8 ctl store");
    doWrite(OWN, 5'd0, 16'h0000);
    expectRead(OWN, 5'd0, 16'h0000, "R8 ctl zero");
    doWrite(OWN, 5'd4, 16'h0061);
    expectRead(OWN, 5'd4, 16'h0061, "R9 adv store");
  endtask

  task automatic testForeign();
    expectRead(5'd2, 5'd0, 16'hFFFF, "R2 foreign ctl");
    expectRead(5'd31, 5'd7, 16'hFFFF, "R2 foreign undef");
    doWrite(5'd2, 5'd0, 16'h0A0A);
    doWrite(5'd0, 5'd4, 16'h0101);
    doWrite(5'd3, 5'd0, 16'h8000);
    expectRead(OWN, 5'd0, 16'h0000, "R3 ctl kept");
    expectRead(OWN, 5'd4, 16'h0061, "R3 adv kept");
  endtask

  task automatic testReadOnly();
    doWrite(OWN, 5'd1, 16'hAAAA);
    doWrite(OWN, 5'd2, 16'hAAAA);
    doWrite(OWN, 5'd3, 16'hAAAA);
    doWrite(OWN, 5'd5, 16'hAAAA);
    doWrite(OWN, 5'd6, 16'hAAAA);
    expectRead(OWN, 5'd1, 16'h786C, "R10 status");
    expectRead(OWN, 5'd2, IDH, "R10 id hi");
    expectRead(OWN, 5'd3, IDL, "R10 id lo");
    expectRead(OWN, 5'd5, 16'h01E1, "R10 partner");
    expectRead(OWN, 5'd6, 16'h0000, "R10 expansion");
    expectRead(OWN, 5'd0, 16'h0000, "R10 ctl");
    expectRead(OWN, 5'd4, 16'h0061, "R10 adv");
  endtask

  task automatic testUndefined();
    for (int i = 6; i < 32; i++) begin
      expectRead(OWN, 5'(i), 16'h0000, "R12 zero index");
    end
  endtask

  task automatic testSoftResetLinkDown();
    @(negedge clk);
    linkOk = 1'b0;
    doWrite(OWN, 5'd0, 16'h0100);
    doWrite(OWN, 5'd4, 16'h0021);
    doWrite(OWN, 5'd0, 16'h8440);
    expectRead(OWN, 5'd0, 16'h3100, "R7 ctl default");
    expectRead(OWN, 5'd4, 16'h01E1, "R7 adv default");
    expectRead(OWN, 5'd1, 16'h7848, "R7 status link down");
    expectRead(OWN, 5'd5, 16'h0080, "R7 partner link down");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testLinkEdge();
    testPlainWrites();
    testForeign();
    testReadOnly();
    testUndefined();
    testSoftResetLinkDown();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule